// File: doc/BRIEF.md
# Column Burst Sequencer

This block generates the column address sequence of a burst inside one 256-column page. A read or write command loads a start column. From the next clock on, the block puts out one column address per cycle in either wrapping sequential order or interleaved (XOR) order. It flags the final beat of every finite burst. The burst length, the ordering and a single-write option come from three small mode fields. The block takes a snapshot of these fields when each command starts.

A burst can be ended early by a stop request. It can also be replaced on any cycle by a new command, which restarts the count from the new column. A full-page burst runs through all columns, wraps from the top of the page to column 0, and continues until it is stopped or replaced. When the single-write option is set, write commands produce exactly one beat, while reads keep the programmed length.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted, and after it until the first command, `col_valid`, `col_last` and `col_addr` are all 0.
- R2: The cycle after `cmd_start` is sampled high, `col_valid` is 1 and `col_addr` equals the sampled `cmd_col`. One further beat follows on each later clock.
- R3: In sequential order with burst length L, beat k carries the start column's bits above log2(L) unchanged. Its low log2(L) bits are (start + k) mod L.
- R4: In interleaved order (`mode_ilv` = 1) with finite burst length L, beat k equals the start column XOR k.
- R5: The length code `mode_len` selects 1 beat (0), 2 beats (1), 4 beats (2), 8 beats (3) or a full page (7). The codes 4, 5 and 6 give 1 beat.
- R6: `col_last` is 1 on the final beat of every finite burst and on no other beat. `col_valid` is 0 in the following cycle unless a new command was sampled.
- R7: A full-page burst steps upward by one column per cycle, goes from 255 to 0, and never raises `col_last`. It always uses sequential order, whatever `mode_ilv` is.
- R8: When `cmd_stop` is sampled high without `cmd_start`, `col_valid` is 0 in the next cycle. When both are high, the new command wins.
- R9: A command sampled during a burst abandons the old sequence. The next cycle shows beat 0 of the new burst from the new column.
- R10: With `mode_wr_single` = 1, a write command (`cmd_write` = 1) produces one beat with `col_last` = 1. Reads keep the programmed length, and with `mode_wr_single` = 0 writes do too.
- R11: The mode fields are captured with the command. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_wr_single | input | 1 | 1 = writes are single-beat |
| cmd_start | input | 1 | New read or write command |
| cmd_write | input | 1 | Command is a write |
| cmd_col | input | 8 | Start column of the command |
| cmd_stop | input | 1 | Terminate the current burst |
| col_valid | output | 1 | A beat is presented this cycle |
| col_addr | output | 8 | Column address of the beat |
| col_last | output | 1 | Final beat of a finite burst |

## Verification
The assertions assume that the inputs are known whenever reset is released, and that `cmd_col` is held stable in the cycle a command is sampled. The stepping check for full-page bursts assumes that a full-page burst is only left through a stop request or a new command. The bench meets these assumptions by changing every input only on the falling clock edge, by keeping all inputs at defined values from time zero, and by pulsing `cmd_start` and `cmd_stop` for exactly one cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  parameter int COLW = 8;
  localparam int LGW = $clog2(COLW + 1);

  // Length code to log2 of the beat count; codes 4..6 collapse to one beat.
  function automatic logic [LGW-1:0] len_log2(input logic [2:0] code);
    case (code)
      3'd1: len_log2 = LGW'(1);
      3'd2: len_log2 = LGW'(2);
      3'd3: len_log2 = LGW'(3);
      3'd7: len_log2 = LGW'(COLW);
      default: len_log2 = '0;
    endcase
  endfunction

  function automatic logic [COLW-1:0] low_mask(input logic [LGW-1:0] lg);
    logic [COLW:0] one_hot;
    one_hot  = (COLW+1)'(1) << lg;
    low_mask = COLW'(one_hot - (COLW+1)'(1));
  endfunction

  // Wrapping count inside the aligned block of size 2**lg.
  function automatic logic [COLW-1:0] seq_col(input logic [COLW-1:0] base,
                                              input logic [COLW-1:0] idx,
                                              input logic [LGW-1:0]  lg);
    logic [COLW-1:0] m;
    m = low_mask(lg);
    seq_col = (base & ~m) | ((base + idx) & m);
  endfunction

  function automatic logic [COLW-1:0] ilv_col(input logic [COLW-1:0] base,
                                              input logic [COLW-1:0] idx,
                                              input logic [LGW-1:0]  lg);
    ilv_col = base ^ (idx & low_mask(lg));
  endfunction
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
(
  input  logic [2:0]     len_code,
  input  logic           ilv_req,
  input  logic           wr_single,
  input  logic           is_write,
  output logic [LGW-1:0] lg,
  output logic           full,
  output logic           ilv
);
  logic force_one;
  logic full_code;

  assign force_one = wr_single & is_write;
  assign full_code = (len_code == 3'd7);

  always_comb begin
    lg   = force_one ? '0 : len_log2(len_code);
    full = full_code & ~force_one;
    ilv  = ilv_req & ~full;
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic [COLW-1:0] col_in,
  input  logic [LGW-1:0]  lg_in,
  input  logic            full_in,
  input  logic            ilv_in,
  output logic            active,
  output logic [COLW-1:0] idx,
  output logic [COLW-1:0] base,
  output logic [LGW-1:0]  lg,
  output logic            full,
  output logic            ilv,
  output logic            last_beat
);
  assign last_beat = active & ~full & (idx == low_mask(lg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      lg     <= '0;
      full   <= 1'b0;
      ilv    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= col_in;
      lg     <= lg_in;
      full   <= full_in;
      ilv    <= ilv_in;
    end else if (stop || last_beat) begin
      active <= 1'b0;
    end else if (active) begin
      idx <= idx + 1'b1;
    end
  end

  a_r6_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !active);
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active);
  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> ($stable(lg) && $stable(full) && $stable(base)));
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
(
  input  logic            active,
  input  logic [COLW-1:0] base,
  input  logic [COLW-1:0] idx,
  input  logic [LGW-1:0]  lg,
  input  logic            ilv,
  output logic [COLW-1:0] addr
);
  always_comb begin
    if (!active)  addr = '0;
    else if (ilv) addr = ilv_col(base, idx, lg);
    else          addr = seq_col(base, idx, lg);
  end

  // R3/R4: bits above the burst block never move.
  a_r3_upper_fixed: assert final (!active ||
    ((addr & ~low_mask(lg)) == (base & ~low_mask(lg))));
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int CW = COLW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_len,
  input  logic          mode_ilv,
  input  logic          mode_wr_single,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic [CW-1:0] cmd_col,
  input  logic          cmd_stop,
  output logic          col_valid,
  output logic [CW-1:0] col_addr,
  output logic          col_last
);
  logic [LGW-1:0]  dec_lg;
  logic            dec_full;
  logic            dec_ilv;
  logic            act;
  logic [COLW-1:0] idx;
  logic [COLW-1:0] base;
  logic [LGW-1:0]  cur_lg;
  logic            cur_full;
  logic            cur_ilv;
  logic            last_beat;
  logic [COLW-1:0] addr;

  colgen_mode_dec u_dec (
    .len_code(mode_len), .ilv_req(mode_ilv), .wr_single(mode_wr_single),
    .is_write(cmd_write), .lg(dec_lg), .full(dec_full), .ilv(dec_ilv)
  );

  colgen_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .stop(cmd_stop),
    .col_in(COLW'(cmd_col)), .lg_in(dec_lg), .full_in(dec_full),
    .ilv_in(dec_ilv), .active(act), .idx(idx), .base(base), .lg(cur_lg),
    .full(cur_full), .ilv(cur_ilv), .last_beat(last_beat)
  );

  colgen_addr_map u_map (
    .active(act), .base(base), .idx(idx), .lg(cur_lg), .ilv(cur_ilv),
    .addr(addr)
  );

  assign col_valid = act;
  assign col_addr  = CW'(addr);
  assign col_last  = last_beat;

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (col_valid && col_addr == $past(cmd_col)));
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_write && mode_wr_single) |=> col_last);
  a_r7_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && cur_full && !cmd_start && !cmd_stop) |=>
      (col_valid && col_addr == CW'($past(col_addr) + 1'b1) && !col_last));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (!col_last && col_addr == '0));
endmodule

// File: tb/burst_colgen_test.sv
module burst_colgen_test;
  localparam int TCK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_len = 3'd0;
  logic       mode_ilv = 1'b0;
  logic       mode_wr_single = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_col = 8'd0;
  logic       cmd_stop = 1'b0;
  logic       col_valid;
  logic [7:0] col_addr;
  logic       col_last;

  int checks = 0;
  int errors = 0;

  always #(TCK/2) clk = ~clk;

  burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .mode_len(mode_len), .mode_ilv(mode_ilv),
    .mode_wr_single(mode_wr_single), .cmd_start(cmd_start),
    .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_stop(cmd_stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic beat(input string req, input int exp_addr, input bit exp_last);
    check(col_valid === 1'b1, req, int'(col_valid), 1);
    check(col_addr == exp_addr[7:0], req, int'(col_addr), exp_addr);
    check(col_last === exp_last, req, int'(col_last), int'(exp_last));
  endtask

  // Issue a command at a falling edge; returns at the falling edge showing beat 0.
  task automatic issue(input int col, input bit wr);
    cmd_start = 1'b1; cmd_col = col[7:0]; cmd_write = wr;
    @(posedge clk); @(negedge clk);
    cmd_start = 1'b0;
  endtask

  function automatic int beats_of(input int code, input bit wr, input bit single);
    if (wr && single) return 1;
    if (code >= 0 && code <= 3) return 1 << code;
    return 1;
  endfunction

  // Finite burst, checked beat by beat, then the idle cycle after it.
  task automatic run_burst(input string req, input int col, input int code,
                           input bit ilv, input bit wr, input bit single);
    int n;
    mode_len = code[2:0]; mode_ilv = ilv; mode_wr_single = single;
    n = beats_of(code, wr, single);
    issue(col, wr);
    for (int k = 0; k < n; k++) begin
      int e;
      if (ilv) e = col ^ k;
      else     e = col - (col % n) + ((col % n) + k) % n;
      beat(req, e, k == n - 1);
      @(negedge clk);
    end
    check(col_valid === 1'b0, {req, " R6 idle after last"}, int'(col_valid), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(col_valid === 1'b0, "R1 valid", int'(col_valid), 0);
    check(col_last === 1'b0, "R1 last", int'(col_last), 0);
    check(col_addr === 8'd0, "R1 addr", int'(col_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_valid === 1'b0, "R1 after release", int'(col_valid), 0);
  endtask

  task automatic t_lengths;
    run_burst("R5 R2 len1", 8'h37, 0, 1'b0, 1'b0, 1'b0);
    run_burst("R5 R3 len2", 8'h37, 1, 1'b0, 1'b0, 1'b0);
    run_burst("R5 R3 len4", 8'h36, 2, 1'b0, 1'b0, 1'b0);
    run_burst("R5 R3 len8", 8'h5D, 3, 1'b0, 1'b0, 1'b0);
    run_burst("R5 reserved6", 8'h12, 6, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_interleave;
    run_burst("R4 ilv4", 8'h81, 2, 1'b1, 1'b0, 1'b0);
    run_burst("R4 ilv8", 8'hF5, 3, 1'b1, 1'b0, 1'b0);
    run_burst("R4 ilv2", 8'h0B, 1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_full_page;
    mode_len = 3'd7; mode_ilv = 1'b1; mode_wr_single = 1'b0;
    issue(250, 1'b0);
    for (int k = 0; k < 12; k++) begin
      beat("R7 full page wrap", (250 + k) % 256, 1'b0);
      @(negedge clk);
    end
    cmd_stop = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_stop = 1'b0;
    check(col_valid === 1'b0, "R8 stop full page", int'(col_valid), 0);
  endtask

  task automatic t_stop_mid;
    mode_len = 3'd3; mode_ilv = 1'b0;
    issue(8'h20, 1'b0);
    beat("R8 pre-stop", 8'h20, 1'b0);
    cmd_stop = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_stop = 1'b0;
    check(col_valid === 1'b0, "R8 stop finite", int'(col_valid), 0);
    @(negedge clk);
    check(col_valid === 1'b0, "R8 stays idle", int'(col_valid), 0);
    // start and stop together: start wins
    cmd_stop = 1'b1;
    issue(8'h44, 1'b0);
    cmd_stop = 1'b0;
    beat("R8 start beats stop", 8'h44, 1'b0);
    @(negedge clk);
    beat("R8 start beats stop b1", 8'h45, 1'b0);
    cmd_stop = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic t_restart;
    mode_len = 3'd3; mode_ilv = 1'b0;
    issue(8'h13, 1'b0);
    beat("R9 old b0", 8'h13, 1'b0);
    @(negedge clk);
    beat("R9 old b1", 8'h14, 1'b0);
    run_burst("R9 restart ilv", 8'h46, 2, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_single_write;
    run_burst("R10 write single", 8'h70, 3, 1'b0, 1'b1, 1'b1);
    run_burst("R10 read keeps length", 8'h70, 3, 1'b0, 1'b0, 1'b1);
    run_burst("R10 write full length", 8'h7A, 2, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_mode_latch;
    mode_len = 3'd2; mode_ilv = 1'b0; mode_wr_single = 1'b0;
    issue(8'h93, 1'b0);
    mode_len = 3'd0; mode_ilv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      beat("R11 mode captured", 8'h90 | ((3 + k) % 4), k == 3);
      @(negedge clk);
    end
    check(col_valid === 1'b0, "R11 end", int'(col_valid), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lengths();
        t_interleave();
        t_full_page();
        t_stop_mid();
        t_restart();
        t_single_write();
        t_mode_latch();
      end
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule